// File: doc/BRIEF.md
# Block-Transfer Host Interrupt Controller

This block drives the level-sensitive interrupt line that a block-transfer host interface raises toward the host processor. It owns a two-bit mask register: one bit lets the host allow interrupts, the other records that an interrupt is outstanding. The interrupt line is the outstanding bit, so the line stays high until something clears it.

Three kinds of event feed it, all arriving from neighbouring logic as single-cycle pulses:
- a host write to the mask register;
- a pulse saying that a response message is ready for the host;
- a request to change the system-management attention flag.

It also samples the current controller-to-host attention flag and system-management attention flag from the register block, a board strap that says whether an interrupt line is wired at all, and a global interrupt enable. Register decoding and the message engine sit outside this block.

Top module: `bt_irq_ctrl`

## Requirements
- R1: The mask register reads back on `mask_rdata`, with bit 0 the interrupt enable and bit 1 the outstanding-interrupt bit. `irq_out` is high exactly when the outstanding bit is set. Both change on the clock edge that samples the causing event.
- R2: While `rst_n` is low, the enable bit and the outstanding bit are both cleared and `irq_out` is low.
- R3: A `rsp_ready` pulse sets the outstanding bit only when `irq_strap`, `irq_glb_en` and the enable bit are all 1. Otherwise it leaves the register unchanged.
- R4: A mask write that turns the enable bit from 0 to 1 sets the outstanding bit at once if `c2h_atn` or `sms_flag` is 1. It does not set it when both flags are 0.
- R5: A mask write that turns the enable bit from 1 to 0 clears the outstanding bit and lowers `irq_out`.
- R6: A mask write with bit 1 set clears an outstanding interrupt. A write with bit 1 clear leaves it set.
- R7: A `sms_req` pulse with `sms_val`=1, while `sms_flag` is 0 and `sms_irq_req` is 1, sets the outstanding bit. This needs `c2h_atn` at 0, the enable bit at 1, `irq_strap` at 1 and `irq_glb_en` at 1. If `c2h_atn` is 1, the pulse does not set it.
- R8: A `sms_req` pulse with `sms_val`=0, while `sms_flag` is 1, clears the outstanding bit when `c2h_atn` is 0. It keeps the bit when `c2h_atn` is 1.
- R9: A `sms_req` pulse whose `sms_val` equals the current `sms_flag` has no effect on the register or on `irq_out`.
- R10: Events in one cycle take effect in a fixed order: the mask write first, then `rsp_ready`, then `sms_req`. A write of 2'b11 that enables while an attention flag is set therefore leaves the outstanding bit clear. `rsp_ready` in the same cycle as an enabling write raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_strap | input | 1 | An interrupt line is wired |
| irq_glb_en | input | 1 | Global interrupt enable |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | 2 | Write data; bit 0 is the enable, bit 1 clears the outstanding bit when set |
| rsp_ready | input | 1 | Pulse: a response is ready for the host |
| c2h_atn | input | 1 | Current controller-to-host attention flag |
| sms_flag | input | 1 | Current system-management attention flag |
| sms_req | input | 1 | Pulse: request to change the system-management attention flag |
| sms_val | input | 1 | Requested value of that flag |
| sms_irq_req | input | 1 | The request may raise an interrupt |
| mask_rdata | output | 2 | Mask register read value |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
Every result is due one clock edge after its stimulus, because the mask register is the only storage between the inputs and the outputs. The bench drives inputs after a falling edge and holds them through one rising edge. It removes them and samples `mask_rdata` and `irq_out` at the next falling edge, half a period after the update. Cases that must not change the outputs are sampled the same way, so a late or missing change would still show. Each scenario starts from a fresh reset, so earlier scenarios cannot leave state that affects a later one.

// File: rtl/bt_irq_pkg.sv
package bt_irq_pkg;
    localparam int MASK_W   = 2;
    localparam int EN_BIT   = 0;
    localparam int PEND_BIT = 1;

    typedef struct packed {
        logic pend;
        logic en;
    } irq_mask_t;
endpackage

// File: rtl/bt_irq_wr_apply.sv
// Applies a host write to the mask register (first stage of the update order).
module bt_irq_wr_apply
    import bt_irq_pkg::*;
(
    input  irq_mask_t         cur,
    input  logic              wr,
    input  logic [MASK_W-1:0] wdata,
    input  logic              atn_any,
    output irq_mask_t         nxt
);
    always_comb begin
        nxt = cur;
        if (wr) begin
            if (wdata[EN_BIT] != cur.en) begin
                if (wdata[EN_BIT]) begin
                    if (atn_any) nxt.pend = 1'b1;
                    nxt.en = 1'b1;
                end else begin
                    nxt.pend = 1'b0;
                    nxt.en   = 1'b0;
                end
            end
            if (wdata[PEND_BIT] && nxt.pend) nxt.pend = 1'b0;
        end
    end
endmodule

// File: rtl/bt_irq_evt_apply.sv
// Applies response-ready, then the attention change, to the post-write mask.
module bt_irq_evt_apply
    import bt_irq_pkg::*;
(
    input  irq_mask_t cur,
    input  logic      irq_ok,
    input  logic      rsp_ready,
    input  logic      c2h_atn,
    input  logic      sms_flag,
    input  logic      sms_req,
    input  logic      sms_val,
    input  logic      sms_irq_req,
    output irq_mask_t nxt
);
    logic sms_change;

    always_comb begin
        nxt        = cur;
        sms_change = sms_req && (sms_val != sms_flag);
        if (rsp_ready && irq_ok && nxt.en && !nxt.pend) nxt.pend = 1'b1;
        if (sms_change) begin
            if (sms_val) begin
                if (sms_irq_req && irq_ok && !c2h_atn && nxt.en) nxt.pend = 1'b1;
            end else if (!c2h_atn && nxt.pend) begin
                nxt.pend = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bt_irq_ctrl.sv
module bt_irq_ctrl
    import bt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_strap,
    input  logic              irq_glb_en,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              rsp_ready,
    input  logic              c2h_atn,
    input  logic              sms_flag,
    input  logic              sms_req,
    input  logic              sms_val,
    input  logic              sms_irq_req,
    output logic [MASK_W-1:0] mask_rdata,
    output logic              irq_out
);
    irq_mask_t mask_q, mask_d, after_wr, after_evt;

    bt_irq_wr_apply u_wr (
        .cur     (mask_q),
        .wr      (mask_wr),
        .wdata   (mask_wdata),
        .atn_any (c2h_atn | sms_flag),
        .nxt     (after_wr)
    );

    bt_irq_evt_apply u_evt (
        .cur         (after_wr),
        .irq_ok      (irq_strap & irq_glb_en),
        .rsp_ready   (rsp_ready),
        .c2h_atn     (c2h_atn),
        .sms_flag    (sms_flag),
        .sms_req     (sms_req),
        .sms_val     (sms_val),
        .sms_irq_req (sms_irq_req),
        .nxt         (after_evt)
    );

    always_comb begin
        mask_d = after_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_rdata[EN_BIT]   = mask_q.en;
    assign mask_rdata[PEND_BIT] = mask_q.pend;
    assign irq_out              = mask_q.pend;

    // R5
    disable_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_wdata[EN_BIT] && mask_q.en) |=> (!irq_out && !mask_rdata[EN_BIT]));

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[PEND_BIT] && irq_out && !rsp_ready && !sms_req) |=> !irq_out);

    // R4
    enable_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata == 2'b01 && !mask_q.en && (c2h_atn || sms_flag) && !sms_req)
        |=> irq_out);

    // R3
    rsp_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && irq_strap && irq_glb_en && mask_q.en && !mask_wr && !sms_req) |=> irq_out);

    // R9
    same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sms_req && sms_val == sms_flag && !mask_wr && !rsp_ready) |=> $stable(irq_out));

    // R1
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(mask_wr || rsp_ready || sms_req));
endmodule

// File: tb/test_bt_irq_ctrl.sv
module test_bt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_strap = 1'b1, irq_glb_en = 1'b1;
    logic       mask_wr = 1'b0;
    logic [1:0] mask_wdata = 2'b00;
    logic       rsp_ready = 1'b0, c2h_atn = 1'b0, sms_flag = 1'b0;
    logic       sms_req = 1'b0, sms_val = 1'b0, sms_irq_req = 1'b0;
    logic [1:0] mask_rdata;
    logic       irq_out;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bt_irq_ctrl i_bt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_strap(irq_strap), .irq_glb_en(irq_glb_en),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .rsp_ready(rsp_ready),
        .c2h_atn(c2h_atn), .sms_flag(sms_flag), .sms_req(sms_req), .sms_val(sms_val),
        .sms_irq_req(sms_irq_req), .mask_rdata(mask_rdata), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [1:0] exp_mask, input logic exp_irq);
        n_chk++;
        if (mask_rdata !== exp_mask || irq_out !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: mask=%b irq=%b expected mask=%b irq=%b",
                     req, mask_rdata, irq_out, exp_mask, exp_irq);
        end
    endtask

    // inputs are set after a falling edge; this runs one rising edge and
    // returns at the next falling edge with the pulses removed
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        mask_wr = 1'b0; rsp_ready = 1'b0; sms_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; c2h_atn = 1'b0; sms_flag = 1'b0;
        irq_strap = 1'b1; irq_glb_en = 1'b1;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] d);
        mask_wr = 1'b1; mask_wdata = d; step();
    endtask

    task automatic sms(input logic v, input logic q);
        sms_req = 1'b1; sms_val = v; sms_irq_req = q; step();
    endtask

    task automatic t_reset();
        do_reset();
        wr(2'b01); rsp_ready = 1'b1; step();
        rst_n = 1'b0; step();
        check("R2 reset clears", 2'b00, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_rsp();
        do_reset();
        irq_glb_en = 1'b0;
        wr(2'b01);
        check("R4 enable without flags", 2'b01, 1'b0);
        rsp_ready = 1'b1; step();
        check("R3 rsp with global off", 2'b01, 1'b0);
        irq_glb_en = 1'b1; irq_strap = 1'b0;
        rsp_ready = 1'b1; step();
        check("R3 rsp with strap off", 2'b01, 1'b0);
        irq_strap = 1'b1;
        rsp_ready = 1'b1; step();
        check("R1 R3 rsp raises", 2'b11, 1'b1);
        wr(2'b01);
        check("R6 write of 0 to pending keeps", 2'b11, 1'b1);
        wr(2'b11);
        check("R6 write of 1 clears", 2'b01, 1'b0);
    endtask

    task automatic t_disable();
        do_reset();
        wr(2'b01); rsp_ready = 1'b1; step();
        wr(2'b00);
        check("R5 disable lowers", 2'b00, 1'b0);
    endtask

    task automatic t_enable_pending();
        do_reset();
        c2h_atn = 1'b1; wr(2'b01);
        check("R4 enable with c2h attention", 2'b11, 1'b1);
        do_reset();
        sms_flag = 1'b1; wr(2'b01);
        check("R4 enable with sms attention", 2'b11, 1'b1);
    endtask

    task automatic t_sms();
        do_reset();
        wr(2'b01);
        sms(1'b1, 1'b0);
        check("R7 no qualifier no raise", 2'b01, 1'b0);
        sms(1'b1, 1'b1);
        check("R7 sms set raises", 2'b11, 1'b1);
        sms_flag = 1'b1;
        sms(1'b0, 1'b0);
        check("R8 sms clear drops", 2'b01, 1'b0);
        rsp_ready = 1'b1; step();
        c2h_atn = 1'b1;
        sms(1'b0, 1'b0);
        check("R8 sms clear kept with c2h", 2'b11, 1'b1);
        wr(2'b11);
        sms_flag = 1'b0;
        sms(1'b1, 1'b1);
        check("R7 no raise with c2h set", 2'b01, 1'b0);
    endtask

    task automatic t_same();
        do_reset();
        wr(2'b01);
        sms_flag = 1'b1;
        sms(1'b1, 1'b1);
        check("R9 same value set ignored", 2'b01, 1'b0);
        sms_flag = 1'b0;
        rsp_ready = 1'b1; step();
        sms(1'b0, 1'b0);
        check("R9 same value clear ignored", 2'b11, 1'b1);
    endtask

    task automatic t_order();
        do_reset();
        sms_flag = 1'b1; wr(2'b11);
        check("R10 enable then ack in one write", 2'b01, 1'b0);
        do_reset();
        mask_wr = 1'b1; mask_wdata = 2'b01; rsp_ready = 1'b1; step();
        check("R10 rsp with enabling write", 2'b11, 1'b1);
    endtask

    initial begin
        t_reset();
        t_rsp();
        t_disable();
        t_enable_pending();
        t_sms();
        t_same();
        t_order();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: done=0 expected done=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule